// File: doc/BRIEF.md
# Serial/Byte Loadable Double-Buffered DAC Code Front End

This block is the digital front end of a 16-bit voltage-output converter. A host writes a code word into an input register in one of two ways. It can shift the word in one bit per clock, with the bit order chosen at a pin. It can also write it as two bytes through separate upper and lower byte enables, in either order. The data input pins serve both modes. In serial mode bit 0 carries the serial data and bit 1 selects the bit order. In byte mode all the pins carry byte data.

A separate load strobe copies the input register into the converter register, and that register drives the code word to the analog section. Many devices can share one strobe and update at the same instant. The bit that leaves the input register during a shift appears on a serial output, so several devices can be chained through their serial inputs. An asynchronous clear forces the output code to the code for 0 V. That code is zero for unipolar straight binary and mid-scale for bipolar offset binary.

Top module: `dacfe_top`

## Requirements
- R1: After reset, `dac_code` is 0x0000 and `ser_out` is 0.
- R2: With `sel`, `ser_mode` and `shift_en` high and `d_in[1]`=1 (most significant bit first), each clock shifts the input register up one place and puts `d_in[0]` into bit 0. After 16 shifts the first bit sent is bit 15.
- R3: With `d_in[1]`=0 (least significant bit first), each shift moves the input register down one place and puts `d_in[0]` into bit 15. After 16 shifts the first bit sent is bit 0.
- R4: `ser_out` is input-register bit 15 when `d_in[1]`=1 and bit 0 when `d_in[1]`=0. Feeding it to a second device's `d_in[0]` chains the two into one 32-bit shift path.
- R5: In byte mode (`ser_mode`=0, `sel`=1), `wr_hi` loads `d_in` into bits 15:8 and `wr_lo` loads `d_in` into bits 7:0. Either byte may be written first, and a byte that is not written keeps its value.
- R6: With `sel` low, nothing is captured. `shift_en` has no effect in byte mode, and `wr_hi`/`wr_lo` have no effect in serial mode.
- R7: `dac_code` changes only at a clock edge where `load` is high, and it then takes the input register as it stood before that edge. A byte written in the same cycle as `load` reaches the output only at a later load.
- R8: While `clr` is high, `dac_code` equals 0x0000 if `bipolar`=0 and 0x8000 if `bipolar`=1, without waiting for a clock, and it follows `bipolar`. `load` is ignored while the clear is in effect. After release, the clear code stays in place until the next load, including after a clear pulse shorter than a clock period.
- R9: Clear leaves the input register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sel | input | 1 | Device select; capture happens only while high |
| ser_mode | input | 1 | 1 = serial loading, 0 = byte loading |
| shift_en | input | 1 | Serial shift enable, one bit per clock |
| wr_hi | input | 1 | Upper byte write enable (byte mode) |
| wr_lo | input | 1 | Lower byte write enable (byte mode) |
| d_in | input | BYTE_W (8) | Byte data; in serial mode bit 0 is data and bit 1 is order |
| load | input | 1 | Transfer strobe, input register to converter register |
| clr | input | 1 | Asynchronous clear to the 0 V code |
| bipolar | input | 1 | 1 = offset binary (clear gives mid-scale), 0 = straight binary |
| ser_out | output | 1 | Bit leaving the input register, for chaining |
| dac_code | output | 2*BYTE_W (16) | Code word to the converter |

## Verification
The bench builds the block with the default BYTE_W of 8, which gives a 16-bit word and a mid-scale clear code of 0x8000. With that width, a full serial load takes exactly 16 shifts and both byte orders can be tried. Two default instances, chained through `ser_out`, make a 32-shift path in which misrouted or misordered bits show up in both output words. Clear is applied between clock edges, both held and as a short pulse, so the asynchronous output path and the pending-clear capture are each reached separately.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic { ORDER_LSB_FIRST = 1'b0, ORDER_MSB_FIRST = 1'b1 } bit_order_e;
  typedef enum logic { MODE_BYTES = 1'b0, MODE_SERIAL = 1'b1 } load_mode_e;
  localparam int unsigned SDI_BIT   = 0;
  localparam int unsigned ORDER_BIT = 1;
endpackage

// File: rtl/dacfe_rst_sync.sv
module dacfe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dacfe_input_reg.sv
module dacfe_input_reg
  import dacfe_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  ser_mode,
  input  logic                  shift_en,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [BYTE_W-1:0]     d_in,
  output logic [2*BYTE_W-1:0]   word_q,
  output logic                  ser_out
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned LANES  = 2;

  load_mode_e        mode;
  bit_order_e        order;
  logic              sdi;
  logic              do_shift;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] word_d;

  assign mode     = load_mode_e'(ser_mode);
  assign order    = bit_order_e'(d_in[ORDER_BIT]);
  assign sdi      = d_in[SDI_BIT];
  assign do_shift = sel && (mode == MODE_SERIAL) && shift_en;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      if (g == LANES - 1) begin : g_upper
        assign lane_we[g] = sel && (mode == MODE_BYTES) && wr_hi;
      end else begin : g_lower
        assign lane_we[g] = sel && (mode == MODE_BYTES) && wr_lo;
      end
    end
  endgenerate

  always_comb begin
    word_d = word_q;
    if (do_shift) begin
      if (order == ORDER_MSB_FIRST) word_d = {word_q[WORD_W-2:0], sdi};
      else                          word_d = {sdi, word_q[WORD_W-1:1]};
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l]) word_d[l*BYTE_W +: BYTE_W] = d_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    word_q <= '0;
    else if (do_shift || |lane_we) word_q <= word_d;
  end

  assign ser_out = (order == ORDER_MSB_FIRST) ? word_q[WORD_W-1] : word_q[0];

  // R2: most significant bit first shifts up, new bit enters at bit 0
  a_r2_msb_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ser_mode && shift_en && d_in[1]) |=>
      (word_q[0] == $past(d_in[0])) && (word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0])));

  // R3: least significant bit first shifts down, new bit enters at the top
  a_r3_lsb_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ser_mode && shift_en && !d_in[1]) |=>
      (word_q[WORD_W-1] == $past(d_in[0])) && (word_q[WORD_W-2:0] == $past(word_q[WORD_W-1:1])));

  // R5: upper byte write leaves the lower byte alone
  a_r5_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !ser_mode && wr_hi && !wr_lo) |=>
      (word_q[WORD_W-1:BYTE_W] == $past(d_in)) && (word_q[BYTE_W-1:0] == $past(word_q[BYTE_W-1:0])));

  // R6: deselected device captures nothing
  a_r6_deselect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(word_q));
endmodule

// File: rtl/dacfe_clear_ctl.sv
module dacfe_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic clear_act
);
  logic pend_q;

  always_ff @(posedge clk or posedge clr or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (clr) pend_q <= 1'b1;
    else          pend_q <= 1'b0;
  end

  assign clear_act = clr || pend_q;
endmodule

// File: rtl/dacfe_dac_reg.sv
module dacfe_dac_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_act,
  input  logic              bipolar,
  input  logic              load,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] dac_code
);
  localparam logic [WORD_W-1:0] MID_CODE  = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] ZERO_CODE = '0;

  logic [WORD_W-1:0] clr_code;
  logic [WORD_W-1:0] dac_q;
  logic [WORD_W-1:0] dac_d;

  assign clr_code = bipolar ? MID_CODE : ZERO_CODE;

  always_comb begin
    dac_d = dac_q;
    if (clear_act) dac_d = clr_code;
    else if (load) dac_d = in_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dac_q <= '0;
    else if (clear_act || load) dac_q <= dac_d;
  end

  assign dac_code = clear_act ? clr_code : dac_q;

  // R7: a strobe without clear transfers the input word of that cycle
  a_r7_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear_act) |=> dac_q == $past(in_word));

  // R7: no strobe and no clear keeps the converter register
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear_act) |=> $stable(dac_q));

  // R8: a clear seen at an edge leaves the mode's zero code in the register
  a_r8_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
    clear_act |=> dac_q == ($past(bipolar) ? MID_CODE : ZERO_CODE));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                ser_mode,
  input  logic                shift_en,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   d_in,
  input  logic                load,
  input  logic                clr,
  input  logic                bipolar,
  output logic                ser_out,
  output logic [2*BYTE_W-1:0] dac_code
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic              rst_n_int;
  logic              clear_act;
  logic [WORD_W-1:0] in_word;

  dacfe_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dacfe_input_reg #(.BYTE_W(BYTE_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sel      (sel),
    .ser_mode (ser_mode),
    .shift_en (shift_en),
    .wr_hi    (wr_hi),
    .wr_lo    (wr_lo),
    .d_in     (d_in),
    .word_q   (in_word),
    .ser_out  (ser_out)
  );

  dacfe_clear_ctl u_clr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr),
    .clear_act (clear_act)
  );

  dacfe_dac_reg #(.WORD_W(WORD_W)) u_dac (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clear_act (clear_act),
    .bipolar   (bipolar),
    .load      (load),
    .in_word   (in_word),
    .dac_code  (dac_code)
  );
endmodule

// File: tb/dacfe_top_test.sv
module dacfe_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, ser_mode = 1'b0, shift_en = 1'b0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, load = 1'b0, clr = 1'b0, bipolar = 1'b0;
  logic [7:0]  d_in = 8'h00;
  logic        a_sout, b_sout;
  logic [15:0] a_code, b_code;
  logic [15:0] exp_in;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dacfe_top #(.BYTE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_mode(ser_mode), .shift_en(shift_en),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .d_in(d_in), .load(load), .clr(clr),
    .bipolar(bipolar), .ser_out(a_sout), .dac_code(a_code));

  dacfe_top #(.BYTE_W(8)) uut_next (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_mode(ser_mode), .shift_en(shift_en),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .d_in({d_in[7:1], a_sout}), .load(load), .clr(clr),
    .bipolar(bipolar), .ser_out(b_sout), .dac_code(b_code));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel = 1'b0; ser_mode = 1'b0; shift_en = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; load = 1'b0;
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n, input bit msb);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = 1'b1; ser_mode = 1'b1; shift_en = 1'b1;
      d_in = {6'b0, msb, msb ? w[n-1-i] : w[i]};
    end
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic write_byte(input bit hi, input logic [7:0] b);
    @(negedge clk);
    sel = 1'b1; ser_mode = 1'b0; d_in = b; wr_hi = hi; wr_lo = !hi;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 reset code", a_code, 16'h0000);
    chk("R1 reset ser_out", {15'b0, a_sout}, 16'h0000);
  endtask

  task automatic t_msb_first();
    shift_bits({16'h0, 16'hA35C}, 16, 1'b1);
    chk("R7 code unchanged before load", a_code, 16'h0000);
    d_in = 8'h02;
    #1 chk("R4 ser_out msb-first is bit 15", {15'b0, a_sout}, 16'h0001);
    pulse_load();
    chk("R2 msb-first word", a_code, 16'hA35C);
    exp_in = 16'hA35C;
  endtask

  task automatic t_lsb_first();
    shift_bits({16'h0, 16'h6E91}, 16, 1'b0);
    d_in = 8'h00;
    #1 chk("R4 ser_out lsb-first is bit 0", {15'b0, a_sout}, 16'h0001);
    pulse_load();
    chk("R3 lsb-first word", a_code, 16'h6E91);
    exp_in = 16'h6E91;
  endtask

  task automatic t_bytes();
    write_byte(1'b1, 8'h3C); write_byte(1'b0, 8'hD2);
    pulse_load();
    chk("R5 high then low", a_code, 16'h3CD2);
    write_byte(1'b0, 8'h47); write_byte(1'b1, 8'hB8);
    pulse_load();
    chk("R5 low then high", a_code, 16'hB847);
    write_byte(1'b0, 8'h05);
    pulse_load();
    chk("R5 upper byte kept", a_code, 16'hB805);
    exp_in = 16'hB805;
  endtask

  task automatic t_ignored();
    @(negedge clk); sel = 1'b0; ser_mode = 1'b1; shift_en = 1'b1; d_in = 8'h03;
    @(negedge clk); @(negedge clk); idle();
    @(negedge clk); sel = 1'b1; ser_mode = 1'b0; shift_en = 1'b1; d_in = 8'hFF;
    @(negedge clk); idle();
    @(negedge clk); sel = 1'b1; ser_mode = 1'b1; wr_hi = 1'b1; wr_lo = 1'b1; d_in = 8'h00;
    @(negedge clk); idle();
    @(negedge clk); sel = 1'b0; ser_mode = 1'b0; wr_hi = 1'b1; wr_lo = 1'b1; d_in = 8'h77;
    @(negedge clk); idle();
    pulse_load();
    chk("R6 ignored strobes keep word", a_code, exp_in);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    sel = 1'b1; ser_mode = 1'b0; wr_hi = 1'b1; d_in = 8'h9A; load = 1'b1;
    @(negedge clk); idle();
    chk("R7 load beside write takes old word", a_code, exp_in);
    pulse_load();
    exp_in = {8'h9A, exp_in[7:0]};
    chk("R7 later load takes new byte", a_code, exp_in);
  endtask

  task automatic t_daisy();
    shift_bits({16'h1234, 16'hC0DE}, 32, 1'b1);
    d_in = 8'h02;
    #1 chk("R4 chain ser_out after 32 shifts", {15'b0, a_sout}, 16'h0001);
    pulse_load();
    chk("R4 chain near device", a_code, 16'hC0DE);
    chk("R4 chain far device", b_code, 16'h1234);
    exp_in = 16'hC0DE;
  endtask

  task automatic t_clear();
    @(negedge clk);
    #1 bipolar = 1'b0; clr = 1'b1;
    #1 chk("R8 async clear unipolar", a_code, 16'h0000);
    bipolar = 1'b1;
    #1 chk("R8 async clear follows bipolar", a_code, 16'h8000);
    @(negedge clk); load = 1'b1;
    @(negedge clk);
    chk("R8 load ignored during clear", a_code, 16'h8000);
    load = 1'b0; clr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 clear code held after release", a_code, 16'h8000);
    pulse_load();
    chk("R9 input word survives clear", a_code, exp_in);
    bipolar = 1'b0;
    @(negedge clk);
    #1 clr = 1'b1;
    #1 clr = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 short pulse captured, unipolar", a_code, 16'h0000);
    pulse_load();
    chk("R9 input word after second clear", a_code, exp_in);
  endtask

  initial begin
    exp_in = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_msb_first();
    t_lsb_first();
    t_bytes();
    t_ignored();
    t_same_cycle();
    t_daisy();
    t_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule